// File: doc/BRIEF.md
# Change-Detect Interrupt Status Bank

This block watches a bank of general-purpose pins, up to eight ports of eight lines each, and records every level change in a per-port status byte whose bits stay set until the host reads that byte. Each pin level passes through a two-flop synchroniser. It is then compared with the level seen one clock earlier. A difference sets the matching status bit. A pin that has been handed to a PWM generator is watched on the PWM's own level instead of the pad, so each PWM edge is recorded as a change.

A per-pin mask vector decides which status bits may pull the shared, active-low interrupt line. A masked pin still records its changes, so the host can poll it. The host reads status through a plain strobe-and-address read port. A read returns the byte as it stood before the read and clears it in the same clock. A change that lands in that same clock is kept for the next read.

Top module: `chg_irq_bank`

## Requirements
- R1: A level change on a pin not assigned to a PWM sets its status bit. The bit becomes 1 at the third rising clock edge after the change, counting two synchroniser flops and the comparison register.
- R2: A status bit, once set, stays 1 until its own port byte is read. Reads of another port's address leave it unchanged.
- R3: When a pin's `pwm_sel` bit is 1, the pin's status bit is set by changes of its `pwm_lvl` bit, one rising edge after the change, and changes of the pad input for that pin have no effect.
- R4: A mask bit of 1 keeps that pin's status bit from driving the interrupt line, while the status bit still sets on a change.
- R5: `irq_n` is 0 exactly when some status bit is 1 and its mask bit is 0, and is 1 otherwise.
- R6: Port p's status byte lives at read address `STATUS_BASE + p` (default base 0x10, port 0 at 0x10, port 7 at 0x17). A cycle with `rd_en` = 1 at that address loads `rd_data` at the same edge with the byte's value from before the read and clears that byte. `rd_data` holds its value while `rd_en` is 0.
- R7: A change that reaches the status logic in the same edge as the clearing read of its port is kept: it is not returned by that read, and it is returned by the next one.
- R8: A read at an address outside the status window returns 0 and clears no status bit.
- R9: After reset, all status bits are 0, `irq_n` is 1 and `rd_data` is 0. Pins and PWM levels are taken to be low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PORTS*PORT_W | Pad levels, port p at bits [p*PORT_W +: PORT_W] |
| pwm_sel | input | NUM_PORTS*PORT_W | 1 = pin watched on its PWM level instead of the pad |
| pwm_lvl | input | NUM_PORTS*PORT_W | PWM output level per pin (on-chip, already synchronous) |
| irq_mask | input | NUM_PORTS*PORT_W | 1 = pin may not assert the interrupt line |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 8 | Read address |
| rd_data | output | PORT_W | Status byte before the clear, loaded at the read edge |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The one collision this block must settle is a pin change arriving at the status logic in the same edge as the read that clears its port. The bench times a pad toggle so that its third synchroniser edge coincides with the read strobe. It then expects that read to return only the older bit, and the following read to return the new bit alone. A second read that is not timed in this way confirms that nothing else leaked through and that the change was not lost.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

   typedef logic [7:0] reg_addr_t;

   // True when addr falls inside [base, base+count)
   function automatic logic in_window(input reg_addr_t addr,
                                      input int unsigned base,
                                      input int unsigned count);
      int unsigned a;
      a = int'(addr);
      return (a >= base) && (a < base + count);
   endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("chg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/chg_port_det.sv
module chg_port_det #(
   parameter int unsigned W      = 8,
   parameter bit          PWM_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_sync_i,
   input  logic [W-1:0] pwm_sel_i,
   input  logic [W-1:0] pwm_lvl_i,
   input  logic         clr_i,
   output logic [W-1:0] status_o
);

   logic [W-1:0] src;
   logic [W-1:0] prev_q;
   logic [W-1:0] chg;
   logic [W-1:0] status_q;

   generate
      if (PWM_EN) begin : g_pwm_mux
         for (genvar b = 0; b < int'(W); b++) begin : g_bit
            assign src[b] = pwm_sel_i[b] ? pwm_lvl_i[b] : pin_sync_i[b];
         end
      end else begin : g_pin_only
         assign src = pin_sync_i;
      end
   endgenerate

   assign chg = src ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         status_q <= '0;
      end else begin
         prev_q   <= src;
         // new changes always win over the clear
         status_q <= (clr_i ? '0 : status_q) | chg;
      end
   end

   assign status_o = status_q;

   // R2: without a clear, no set bit may drop
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R1: a detected difference shows up in status next cycle
   p_change_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |=> ((status_q & $past(chg)) == $past(chg)));

   // R7: a clear leaves exactly the changes of its own cycle
   p_clear_keeps_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (status_q == $past(chg)));

endmodule

// File: rtl/chg_rd_port.sv
module chg_rd_port
   import chg_irq_pkg::*;
#(
   parameter int unsigned NP   = 8,
   parameter int unsigned W    = 8,
   parameter int unsigned BASE = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en_i,
   input  reg_addr_t       rd_addr_i,
   input  logic [NP*W-1:0] status_i,
   output logic [NP-1:0]   clr_o,
   output logic [W-1:0]    rd_data_o
);

   localparam int unsigned IDX_W = (NP > 1) ? $clog2(NP) : 1;

   generate
      if (BASE + NP > 256) begin : g_bad_window
         $error("chg_rd_port: status window exceeds address space");
      end
   endgenerate

   logic             hit;
   reg_addr_t        offs;
   logic [IDX_W-1:0] idx;
   logic [W-1:0]     sel;
   logic [W-1:0]     rd_q;

   assign hit  = in_window(rd_addr_i, BASE, NP);
   assign offs = rd_addr_i - reg_addr_t'(BASE);
   assign idx  = offs[IDX_W-1:0];

   always_comb begin
      sel = '0;
      for (int p = 0; p < int'(NP); p++) begin
         if (idx == IDX_W'(p)) sel = status_i[p*W +: W];
      end
   end

   generate
      for (genvar p = 0; p < int'(NP); p++) begin : g_clr
         assign clr_o[p] = rd_en_i && hit && (idx == IDX_W'(p));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_en_i) rd_q <= hit ? sel : '0;
   end

   assign rd_data_o = rd_q;

   // R8: a miss clears nothing and returns zero
   p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !hit) |=> (rd_q == '0));

   // R6: one read clears at most one port
   p_one_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));

   // R6: read data holds between reads
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_q));

endmodule

// File: rtl/chg_irq_bank.sv
module chg_irq_bank
   import chg_irq_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 8,
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned STATUS_BASE = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PWM_EN      = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
   input  logic [NUM_PORTS*PORT_W-1:0] pwm_sel,
   input  logic [NUM_PORTS*PORT_W-1:0] pwm_lvl,
   input  logic [NUM_PORTS*PORT_W-1:0] irq_mask,
   input  logic                        rd_en,
   input  logic [7:0]                  rd_addr,
   output logic [PORT_W-1:0]           rd_data,
   output logic                        irq_n
);

   localparam int unsigned TOT_W = NUM_PORTS * PORT_W;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > 8) begin : g_bad_ports
         $error("chg_irq_bank: NUM_PORTS must be 1..8");
      end
      if (PORT_W < 1 || PORT_W > 8) begin : g_bad_width
         $error("chg_irq_bank: PORT_W must be 1..8");
      end
   endgenerate

   logic [TOT_W-1:0]     pin_sync;
   logic [TOT_W-1:0]     status_all;
   logic [NUM_PORTS-1:0] clr;
   logic [NUM_PORTS-1:0] port_req;

   chg_sync #(.W(TOT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (pin_sync)
   );

   generate
      for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
         chg_port_det #(.W(PORT_W), .PWM_EN(PWM_EN)) u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_sync_i (pin_sync[p*PORT_W +: PORT_W]),
            .pwm_sel_i  (pwm_sel[p*PORT_W +: PORT_W]),
            .pwm_lvl_i  (pwm_lvl[p*PORT_W +: PORT_W]),
            .clr_i      (clr[p]),
            .status_o   (status_all[p*PORT_W +: PORT_W])
         );
         assign port_req[p] = |(status_all[p*PORT_W +: PORT_W] &
                                ~irq_mask[p*PORT_W +: PORT_W]);
      end
   endgenerate

   chg_rd_port #(.NP(NUM_PORTS), .W(PORT_W), .BASE(STATUS_BASE)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .status_i  (status_all),
      .clr_o     (clr),
      .rd_data_o (rd_data)
   );

   assign irq_n = ~(|port_req);

   // R4: with every pin masked the line stays released
   p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (&irq_mask) |-> irq_n);

   // R5: with no status pending the line stays released
   p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_all == '0) |-> irq_n);

endmodule

// File: tb/tb_chg_irq_bank.sv
module tb_chg_irq_bank;

   localparam int NP = 8;
   localparam int W  = 8;
   localparam int BASE = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP*W-1:0] pin_in = '0, pwm_sel = '0, pwm_lvl = '0, irq_mask = '0;
   logic rd_en = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [W-1:0] rd_data;
   logic irq_n;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   chg_irq_bank #(.NUM_PORTS(NP), .PORT_W(W), .STATUS_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pwm_sel(pwm_sel),
      .pwm_lvl(pwm_lvl), .irq_mask(irq_mask), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   // strobe one read; returns rd_data sampled after the read edge
   task automatic rd(input int addr, output int val);
      rd_en = 1'b1;
      rd_addr = 8'(addr);
      @(negedge clk);
      rd_en = 1'b0;
      val = int'(rd_data);
   endtask

   initial begin
      int v;
      @(negedge clk); @(negedge clk);
      // R9 reset state
      chk("R9 irq_n", int'(irq_n), 1);
      chk("R9 rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      waitn(3);
      chk("R9 irq_n after release", int'(irq_n), 1);

      // R1/R2/R5/R6 sweep over every pin
      for (int p = 0; p < NP; p++) begin
         for (int b = 0; b < W; b++) begin
            pin_in[p*W+b] = ~pin_in[p*W+b];
            waitn(2);
            chk("R1 no early set", int'(irq_n), 1);
            waitn(1);
            chk("R5 irq asserted", int'(irq_n), 0);
            rd(BASE + ((p + 1) % NP), v);
            chk("R2 other port reads zero", v, 0);
            rd(BASE + p, v);
            chk("R6 R1 status value", v, 1 << b);
            chk("R5 irq released", int'(irq_n), 1);
            waitn(1);
            chk("R6 rd_data holds", int'(rd_data), 1 << b);
            rd(BASE + p, v);
            chk("R6 cleared by read", v, 0);
         end
      end

      // R3 PWM path: pads all 1 now, align PWM levels first
      pwm_lvl = '1;
      pwm_sel[2*W+3] = 1'b1;
      waitn(2);
      rd(BASE + 2, v);
      chk("R3 switch clean", v, 0);
      pwm_lvl[2*W+3] = 1'b0;
      waitn(1);
      chk("R3 pwm edge irq", int'(irq_n), 0);
      rd(BASE + 2, v);
      chk("R3 pwm edge status", v, 8);
      pin_in[2*W+3] = 1'b0;
      waitn(4);
      rd(BASE + 2, v);
      chk("R3 pad ignored", v, 0);
      chk("R3 irq idle", int'(irq_n), 1);

      // R4 mask
      irq_mask[4*W +: W] = 8'hFF;
      pin_in[4*W+0] = 1'b0;
      waitn(4);
      chk("R4 masked no irq", int'(irq_n), 1);
      pin_in[5*W+0] = 1'b0;
      waitn(4);
      chk("R5 unmasked irq", int'(irq_n), 0);
      rd(BASE + 5, v);
      chk("R5 port5 value", v, 1);
      chk("R4 irq after unmasked clear", int'(irq_n), 1);
      rd(BASE + 4, v);
      chk("R4 masked status set", v, 1);
      irq_mask = '0;

      // R7 change coinciding with the clearing read
      pin_in[1*W+2] = 1'b0;
      waitn(4);
      pin_in[1*W+5] = 1'b0;
      waitn(2);
      rd(BASE + 1, v);
      chk("R7 read returns old only", v, 4);
      chk("R7 irq still pending", int'(irq_n), 0);
      rd(BASE + 1, v);
      chk("R7 new change kept", v, 32);

      // R8 reads outside the window
      pin_in[0] = 1'b0;
      waitn(4);
      rd(BASE - 1, v);
      chk("R8 below window", v, 0);
      rd(BASE + NP, v);
      chk("R8 above window", v, 0);
      chk("R8 irq kept", int'(irq_n), 0);
      rd(BASE, v);
      chk("R8 status survived", v, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule